// File: doc/BRIEF.md
# Receive Descriptor Ring Completion Engine

This block runs the receive side of a descriptor-ring DMA engine. Incoming data segments arrive as completion events, each one carrying a byte length. For every accepted segment, the block writes the flags word of the descriptor at its current DMA index. That single write carries the received length and the done flag. The block then moves the DMA index one slot on and wraps it at the programmed ring size. It also sets a per-queue completion status bit. A mask register gates that bit onto the interrupt line.

Software owns the ring through a CPU index. The CPU index names the last descriptor that software has reclaimed. The engine may fill slots up to that index but never the slot it names. When the DMA index reaches the CPU index, the ring is full and the block stops accepting segments until software moves the CPU index on. Software finds the number of finished descriptors as (DMA index − (CPU index + 1)) mod ring size. The block moves the DMA index once per finished descriptor so that this sum stays exact.

Configuration goes through a small word-addressed register port. Register number 0 holds the ring base, 1 the ring size, 2 the CPU index, 3 the DMA index (read only), 4 the reset control, 5 the interrupt status and 6 the interrupt mask.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset the DMA index reads 0, the ring size reads DEF_CNT (8), the CPU index reads DEF_CNT−1 (7), and the mask, the status and `irq` are all zero.
- R2: `seg_ready` is high exactly when the DMA index differs from the CPU index. A segment offered while they are equal produces no descriptor write and leaves the DMA index unchanged.
- R3: A segment accepted at a clock edge gives `dw_valid` high for the following cycle only. In that cycle `dw_addr` = base + 16·index + 4, where index is the DMA index at acceptance. `dw_data` has bit 31 = 1, bits 29:16 = length, and every other bit 0.
- R4: The DMA index moves on by one per accepted segment and wraps from size−1 to 0. It keeps (DMA − (CPU+1)) mod size equal to the number of filled slots that have not been reclaimed.
- R5: Writing register 4 with bit 16+CHAN set (bit 16 by default) clears the DMA index to 0 at that edge. Other bits of that register have no effect.
- R6: Each descriptor write sets status bit 16+CHAN (register 5) at the same edge. The other status bits always read 0.
- R7: Writing register 5 clears each status bit written as one and leaves bits written as zero unchanged. A completion in the same cycle wins over the clear.
- R8: `irq` is the OR of status AND mask. It follows register changes in the same cycle (default IRQ_REG=0).
- R9: Registers 0, 1, 2 and 6 read back the last value written to them. `rx_busy` is high exactly in the cycles where `dw_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register number |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| seg_valid | input | 1 | Segment completion event present |
| seg_len | input | 14 | Byte length of the segment |
| seg_ready | output | 1 | Ring has a free slot; the segment is taken when `seg_valid` is also high |
| dw_valid | output | 1 | Descriptor flags write strobe |
| dw_addr | output | ADDR_W | Byte address of the descriptor flags word |
| dw_data | output | 32 | Flags word: done flag and length |
| rx_busy | output | 1 | A descriptor is being written |
| irq | output | 1 | Interrupt request |

## Verification
`seg_ready` and `reg_rdata` are combinational, so they are due in the same cycle as the state they reflect. The descriptor write, the DMA index step, the status bit and the register writes all take effect at the first clock edge after their stimulus. `irq` follows them in that same cycle. The bench drives every input on the falling edge. It checks `seg_ready` just after driving and before the rising edge. It checks the write port, `rx_busy` and `irq` on the next falling edge, against a model it steps in the same order. Register contents are read back between cycles, with no clock involved.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   typedef enum logic [2:0] {
      RA_BASE  = 3'd0,
      RA_COUNT = 3'd1,
      RA_CPU   = 3'd2,
      RA_DMA   = 3'd3,
      RA_RST   = 3'd4,
      RA_STAT  = 3'd5,
      RA_MASK  = 3'd6
   } rxr_reg_e;

   localparam int LEN_W      = 14;  // length field width in the flags word
   localparam int LEN_LSB    = 16;  // length field position
   localparam int DONE_BIT   = 31;  // done flag position
   localparam int DESC_SHIFT = 4;   // descriptor stride = 16 bytes
   localparam int FLAGS_OFS  = 4;   // flags word offset inside a descriptor
   localparam int RXQ_LSB    = 16;  // receive queue bits start here
endpackage

// File: rtl/rxr_index.sv
module rxr_index #(
   parameter int IDX_W   = 4,
   parameter int DEF_CNT = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W:0]   ring_cnt,
   input  logic [IDX_W-1:0] cpu_idx,
   input  logic             advance,
   input  logic             clear,
   output logic [IDX_W-1:0] dma_idx,
   output logic             room
);
   localparam logic [IDX_W:0] ONE = (IDX_W+1)'(1);

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] idx_inc;
   logic             at_last;

   assign at_last = ({1'b0, idx_q} + ONE) >= ring_cnt;
   assign idx_inc = at_last ? '0 : idx_q + 1'b1;
   assign room    = (idx_q != cpu_idx);
   assign dma_idx = idx_q;

   always_ff @(posedge clk) begin
      if (rst)          idx_q <= '0;
      else if (clear)   idx_q <= '0;
      else if (advance) idx_q <= idx_inc;
   end

   // R4: the index only moves on an accepted segment or a clear
   p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (!advance && !clear) |=> $stable(dma_idx));
   // R5: a clear always lands on slot zero
   p_clear_r5: assert property (@(posedge clk) disable iff (rst)
      clear |=> (dma_idx == '0));
endmodule

// File: rtl/rxr_desc_wr.sv
module rxr_desc_wr #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 4
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      fire,
   input  logic [IDX_W-1:0]          idx,
   input  logic [rxr_pkg::LEN_W-1:0] len,
   input  logic [ADDR_W-1:0]         base,
   output logic                      dw_valid,
   output logic [ADDR_W-1:0]         dw_addr,
   output logic [31:0]               dw_data
);
   import rxr_pkg::*;

   logic [ADDR_W-1:0] slot_addr;
   logic [31:0]       flags;

   assign slot_addr = base + (ADDR_W'(idx) << DESC_SHIFT) + ADDR_W'(FLAGS_OFS);

   always_comb begin
      flags = '0;
      flags[DONE_BIT] = 1'b1;
      flags[LEN_LSB +: LEN_W] = len;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         dw_valid <= 1'b0;
         dw_addr  <= '0;
         dw_data  <= '0;
      end else begin
         dw_valid <= fire;
         if (fire) begin
            dw_addr <= slot_addr;
            dw_data <= flags;
         end
      end
   end

   // R3: exactly one write strobe per accepted segment, one cycle later
   p_fire_r3: assert property (@(posedge clk) disable iff (rst)
      fire |=> dw_valid);
   p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
      !fire |=> !dw_valid);
endmodule

// File: rtl/rxr_irq.sv
module rxr_irq #(
   parameter int QBIT    = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        set,
   input  logic        wr_stat,
   input  logic        wr_mask,
   input  logic [31:0] wdata,
   output logic [31:0] status,
   output logic [31:0] mask,
   output logic        irq
);
   logic stat_q;
   logic [31:0] mask_q;
   logic pend;

   always_ff @(posedge clk) begin
      if (rst) begin
         stat_q <= 1'b0;
         mask_q <= '0;
      end else begin
         if (set)                      stat_q <= 1'b1;
         else if (wr_stat && wdata[QBIT]) stat_q <= 1'b0;
         if (wr_mask) mask_q <= wdata;
      end
   end

   always_comb begin
      status       = '0;
      status[QBIT] = stat_q;
   end
   assign mask = mask_q;
   assign pend = |(status & mask_q);

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (rst) irq_q <= 1'b0;
         else     irq_q <= pend;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = pend;
      // R8: no request without an enabled pending bit
      p_masked_r8: assert property (@(posedge clk) disable iff (rst)
         (mask[QBIT] == 1'b0) |-> !irq);
   end

   // R6: a completion is always recorded
   p_set_r6: assert property (@(posedge clk) disable iff (rst)
      set |=> status[QBIT]);
   // R7: a one written without a completion clears the bit
   p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_stat && wdata[QBIT] && !set) |=> !status[QBIT]);
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine #(
   parameter int ADDR_W  = 32,
   parameter int IDX_W   = 4,
   parameter int DEF_CNT = 8,
   parameter int CHAN    = 0,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      reg_we,
   input  logic [2:0]                reg_addr,
   input  logic [31:0]               reg_wdata,
   output logic [31:0]               reg_rdata,
   input  logic                      seg_valid,
   input  logic [rxr_pkg::LEN_W-1:0] seg_len,
   output logic                      seg_ready,
   output logic                      dw_valid,
   output logic [ADDR_W-1:0]         dw_addr,
   output logic [31:0]               dw_data,
   output logic                      rx_busy,
   output logic                      irq
);
   import rxr_pkg::*;

   localparam int QBIT = RXQ_LSB + CHAN;
   localparam logic [IDX_W:0]   CNT_RST = (IDX_W+1)'(DEF_CNT);
   localparam logic [IDX_W-1:0] CPU_RST = IDX_W'(DEF_CNT - 1);

   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie in 8..32");
   end
   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
      $error("IDX_W must lie in 1..12");
   end
   if (DEF_CNT < 2 || DEF_CNT > (1 << IDX_W)) begin : g_bad_cnt
      $error("DEF_CNT must lie in 2..2**IDX_W");
   end
   if (CHAN < 0 || CHAN > 11) begin : g_bad_chan
      $error("CHAN must lie in 0..11");
   end

   logic [ADDR_W-1:0] base_q;
   logic [IDX_W:0]    cnt_q;
   logic [IDX_W-1:0]  cpu_q;
   logic [IDX_W-1:0]  dma_idx;
   logic              room;
   logic              accept;
   logic              idx_clear;
   logic [31:0]       status;
   logic [31:0]       mask;
   rxr_reg_e          ra;

   assign ra        = rxr_reg_e'(reg_addr);
   assign seg_ready = room;
   assign accept    = seg_valid && room;
   assign idx_clear = reg_we && (ra == RA_RST) && reg_wdata[QBIT];

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
         cnt_q  <= CNT_RST;
         cpu_q  <= CPU_RST;
      end else if (reg_we) begin
         case (ra)
            RA_BASE:  base_q <= reg_wdata[ADDR_W-1:0];
            RA_COUNT: cnt_q  <= reg_wdata[IDX_W:0];
            RA_CPU:   cpu_q  <= reg_wdata[IDX_W-1:0];
            default:  ;
         endcase
      end
   end

   rxr_index #(.IDX_W(IDX_W), .DEF_CNT(DEF_CNT)) u_index (
      .clk(clk), .rst(rst), .ring_cnt(cnt_q), .cpu_idx(cpu_q),
      .advance(accept), .clear(idx_clear), .dma_idx(dma_idx), .room(room)
   );

   rxr_desc_wr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_desc (
      .clk(clk), .rst(rst), .fire(accept), .idx(dma_idx), .len(seg_len),
      .base(base_q), .dw_valid(dw_valid), .dw_addr(dw_addr), .dw_data(dw_data)
   );

   rxr_irq #(.QBIT(QBIT), .IRQ_REG(IRQ_REG)) u_irq (
      .clk(clk), .rst(rst), .set(accept),
      .wr_stat(reg_we && (ra == RA_STAT)), .wr_mask(reg_we && (ra == RA_MASK)),
      .wdata(reg_wdata), .status(status), .mask(mask), .irq(irq)
   );

   assign rx_busy = dw_valid;

   always_comb begin
      case (ra)
         RA_BASE:  reg_rdata = 32'(base_q);
         RA_COUNT: reg_rdata = 32'(cnt_q);
         RA_CPU:   reg_rdata = 32'(cpu_q);
         RA_DMA:   reg_rdata = 32'(dma_idx);
         RA_STAT:  reg_rdata = status;
         RA_MASK:  reg_rdata = mask;
         default:  reg_rdata = '0;
      endcase
   end

   // R2: a full ring refuses segments
   p_full_stall_r2: assert property (@(posedge clk) disable iff (rst)
      (dma_idx == cpu_q) |-> !seg_ready);
   // R2: a refused segment leaves the index alone
   p_no_fill_r2: assert property (@(posedge clk) disable iff (rst)
      (seg_valid && !seg_ready && !idx_clear) |=> $stable(dma_idx));
   // R9: busy tracks the write strobe
   p_busy_r9: assert property (@(posedge clk) disable iff (rst)
      rx_busy == dw_valid);
endmodule

// File: tb/sim_rx_ring_engine.sv
module sim_rx_ring_engine;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        seg_valid = 1'b0;
   logic [13:0] seg_len = '0;
   logic        seg_ready, dw_valid, rx_busy, irq;
   logic [31:0] dw_addr, dw_data;

   int n_chk = 0;
   int n_bad = 0;

   int m_dma, m_cpu, m_cnt;
   logic [31:0] m_base, m_mask;
   logic m_stat;

   always #10 clk = ~clk;

   rx_ring_engine u0 (
      .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seg_valid(seg_valid),
      .seg_len(seg_len), .seg_ready(seg_ready), .dw_valid(dw_valid),
      .dw_addr(dw_addr), .dw_data(dw_data), .rx_busy(rx_busy), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic int finished();
      return (((m_dma - m_cpu - 1) % m_cnt) + m_cnt) % m_cnt;
   endfunction

   function automatic logic [31:0] flags_of(input logic [13:0] l);
      return {1'b1, 1'b0, l, 16'h0000};
   endfunction

   task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   // one clock: drive on the falling edge, check ready, step the model, check outputs
   task automatic cyc(input logic sv, input logic [13:0] l, input logic we,
                      input logic [2:0] a, input logic [31:0] wd);
      logic acc;
      logic [31:0] e_addr;
      seg_valid = sv; seg_len = l; reg_we = we; reg_addr = a; reg_wdata = wd;
      #1;
      chk("R2 seg_ready", 32'(seg_ready), 32'(m_dma != m_cpu));
      acc = sv && (m_dma != m_cpu);
      e_addr = m_base + 32'(m_dma) * 16 + 4;
      if (we && a == 3'd4 && wd[16]) m_dma = 0;
      else if (acc) m_dma = (m_dma + 1 >= m_cnt) ? 0 : m_dma + 1;
      if (acc) m_stat = 1'b1;
      else if (we && a == 3'd5 && wd[16]) m_stat = 1'b0;
      if (we) begin
         case (a)
            3'd0: m_base = wd;
            3'd1: m_cnt  = int'(wd[4:0]);
            3'd2: m_cpu  = int'(wd[3:0]);
            3'd6: m_mask = wd;
            default: ;
         endcase
      end
      @(posedge clk);
      @(negedge clk);
      seg_valid = 1'b0; reg_we = 1'b0;
      chk("R3 dw_valid", 32'(dw_valid), 32'(acc));
      chk("R9 rx_busy", 32'(rx_busy), 32'(acc));
      if (acc) begin
         chk("R3 dw_addr", dw_addr, e_addr);
         chk("R3 dw_data", dw_data, flags_of(l));
      end
      chk("R8 irq", 32'(irq), 32'(m_stat & m_mask[16]));
   endtask

   task automatic idle();
      cyc(1'b0, 14'd0, 1'b0, 3'd0, 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd20240611);
      m_dma = 0; m_cpu = 7; m_cnt = 8; m_base = '0; m_mask = '0; m_stat = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      // R1 reset state
      rd("R1 dma", 3'd3, 32'd0);
      rd("R1 cpu", 3'd2, 32'd7);
      rd("R1 count", 3'd1, 32'd8);
      rd("R1 mask", 3'd6, 32'd0);
      rd("R1 status", 3'd5, 32'd0);
      chk("R1 irq", 32'(irq), 32'd0);

      // R9 readback
      cyc(1'b0, 0, 1'b1, 3'd0, 32'h1000_0000);
      rd("R9 base", 3'd0, 32'h1000_0000);

      // R2/R3/R4 fill seven slots, eighth stalls
      for (int i = 0; i < 7; i++) cyc(1'b1, 14'(i * 1000 + 3), 1'b0, 3'd0, 0);
      rd("R4 dma after fill", 3'd3, 32'd7);
      chk("R4 finished count", 32'(finished()), 32'd7);
      cyc(1'b1, 14'h3fff, 1'b0, 3'd0, 0);
      rd("R2 dma unchanged when full", 3'd3, 32'd7);

      // R6/R8 status and mask
      rd("R6 status bit 16", 3'd5, 32'h0001_0000);
      chk("R8 irq masked", 32'(irq), 32'd0);
      cyc(1'b0, 0, 1'b1, 3'd6, 32'h0001_0000);
      chk("R8 irq unmasked", 32'(irq), 32'd1);
      rd("R9 mask", 3'd6, 32'h0001_0000);
      // R7 write zero keeps, write one clears
      cyc(1'b0, 0, 1'b1, 3'd5, 32'hfffe_ffff);
      rd("R7 zero write keeps", 3'd5, 32'h0001_0000);
      cyc(1'b0, 0, 1'b1, 3'd5, 32'h0001_0000);
      rd("R7 one write clears", 3'd5, 32'd0);
      chk("R8 irq after clear", 32'(irq), 32'd0);

      // R4 reclaim and wrap
      cyc(1'b0, 0, 1'b1, 3'd2, 32'd6);
      for (int i = 0; i < 3; i++) cyc(1'b1, 14'(i + 40), 1'b0, 3'd0, 0);
      rd("R4 wrapped dma", 3'd3, 32'd2);
      // R7 set beats clear in the same cycle
      cyc(1'b0, 0, 1'b1, 3'd5, 32'h0001_0000);
      cyc(1'b1, 14'd77, 1'b1, 3'd5, 32'h0001_0000);
      rd("R7 set wins", 3'd5, 32'h0001_0000);

      // R5 reset control
      cyc(1'b0, 0, 1'b1, 3'd4, 32'h0000_ffff);
      rd("R5 other bits ignored", 3'd3, 32'd3);
      cyc(1'b0, 0, 1'b1, 3'd4, 32'h0001_0000);
      rd("R5 dma cleared", 3'd3, 32'd0);

      // R4 smaller ring of five
      cyc(1'b0, 0, 1'b1, 3'd1, 32'd5);
      cyc(1'b0, 0, 1'b1, 3'd2, 32'd4);
      rd("R9 count", 3'd1, 32'd5);
      for (int i = 0; i < 5; i++) cyc(1'b1, 14'(i + 9), 1'b0, 3'd0, 0);
      rd("R2 five-ring full", 3'd3, 32'd4);
      cyc(1'b0, 0, 1'b1, 3'd2, 32'd3);
      cyc(1'b1, 14'd5, 1'b0, 3'd0, 0);
      rd("R4 five-ring wrap", 3'd3, 32'd0);

      // random phase on an eight-slot ring
      cyc(1'b0, 0, 1'b1, 3'd1, 32'd8);
      cyc(1'b0, 0, 1'b1, 3'd2, 32'd7);
      cyc(1'b0, 0, 1'b1, 3'd4, 32'h0001_0000);
      for (int n = 0; n < 4000; n++) begin
         int unsigned r;
         int k;
         r = $urandom;
         if (r[2:0] == 3'd0 && finished() > 0) begin
            k = 1 + int'($urandom % 32'(finished()));
            cyc(r[8], 14'($urandom), 1'b1, 3'd2, 32'((m_cpu + k) % m_cnt));
         end else if (r[6:3] == 4'd0) begin
            cyc(r[8], 14'($urandom), 1'b1, 3'd5, {15'd0, r[9], 16'd0});
         end else if (r[7:3] == 5'd1) begin
            cyc(r[8], 14'($urandom), 1'b1, 3'd6, {15'd0, r[10], 16'd0});
         end else begin
            cyc(r[12:11] != 2'd0, 14'($urandom), 1'b0, 3'd0, 0);
         end
         if (n % 500 == 0) begin
            rd("R4 random dma", 3'd3, 32'(m_dma));
            chk("R4 random finished", 32'(finished()),
                32'(((m_dma - m_cpu - 1) % 8 + 8) % 8));
         end
      end
      idle();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule